// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Split Masking

This block decides which of up to sixteen bus masters owns the address phase of a shared, pipelined system bus. Each master raises a request line and, for indivisible sequences, a lock line. The arbiter drives a one-hot grant vector, a 4-bit owner tag for the current address phase, and a locked-phase flag. Priority is fixed: the lowest index wins. The grant only moves at a clock edge where the bus-ready input is high, and it does not move while the granted master keeps its lock line raised.

A slave that cannot finish a transfer soon can answer with a split response. The arbiter then hides the request of the master that owned that data phase. The arbiter learns this master by keeping a registered copy of the owner tag, taken on every ready-high edge. The master stays hidden until the slave pulses that master's bit on the 16-bit split-release vector. That vector is sampled on every cycle, so one cycle of release is enough. If no master is both requesting and visible, master 0 takes the bus as the default owner.

Top module: `arb_split_arbiter`

## Requirements
- R1: While reset is asserted (synchronous, active low), the grant becomes one-hot master 0, the owner tag becomes 0, the locked flag becomes 0 and all split masks are cleared.
- R2: The grant vector is one-hot in every cycle.
- R3: At a ready-high edge where no lock hold applies, the grant moves to the lowest-indexed master that is requesting and not masked.
- R4: At an edge with ready low, the grant, owner tag and locked flag keep their values.
- R5: At a ready-high edge, the owner tag takes the index of the master that was granted just before that edge.
- R6: At a ready-high edge, the locked flag takes the lock input of the master that was granted just before that edge.
- R7: While the granted master holds its lock input high and is not masked, the grant does not change, even when a higher-priority master requests.
- R8: The response code 2'b11 (split) masks the master whose index is in the data-phase tag. The data-phase tag is a register that copies the owner tag at each ready-high edge. Response codes 2'b00, 2'b01 and 2'b10 mask nothing.
- R9: A release pulse on bit n of the split-release vector clears the mask of master n at the next edge. A release wins over a split response aimed at the same master in the same cycle.
- R10: When no master is both requesting and unmasked, a ready-high edge without a lock hold grants master 0.
- R11: Release bits at indices at or above the number of masters have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_MASTERS | Request line of each master |
| lock | input | NUM_MASTERS | Lock line of each master |
| ready | input | 1 | Bus ready; high when the current transfer completes |
| resp | input | 2 | Slave response code; 2'b11 is split |
| split_release | input | SPLIT_W (16) | ORed release pulses from the slaves, one bit per master |
| grant | output | NUM_MASTERS | One-hot grant |
| owner | output | TAG_W (4) | Index of the address-phase owner |
| owner_locked | output | 1 | High when the current address phase belongs to a locked sequence |

## Verification
Two events can land in the same cycle: a split response that masks the data-phase master, and a release pulse for that same master. The bench first makes master 1 the data-phase owner. It then applies a split response and a release of bit 1 together in a ready-low cycle. Master 1 must still hold the grant after the next ready-high edge. One cycle later a split response alone must push the grant to master 0. A cycle-by-cycle reference model also runs a long stream of mixed traffic in which these events often collide, and the grant, owner tag and locked flag are compared against it on every clock.

// File: rtl/arb_pkg.sv
// Package: shared response codes for the split-masking arbiter.
// Assumes the two-bit response encoding used throughout the bus.
package arb_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } resp_e;
endpackage

// File: rtl/arb_fixed_pick.sv
// Module: arb_fixed_pick
// Combinational fixed-priority picker. Index 0 has the highest priority.
// If no candidate is eligible, index 0 (the default owner) is returned.
// Assumes NUM_MASTERS <= 2**TAG_W.
module arb_fixed_pick #(
    parameter int NUM_MASTERS = 4,
    parameter int TAG_W       = 4
) (
    input  logic [NUM_MASTERS-1:0] eligible,
    output logic [NUM_MASTERS-1:0] pick_onehot,
    output logic [TAG_W-1:0]       pick_idx,
    output logic                   any_eligible
);
    // Scan from the highest index down so that the lowest eligible index is kept last.
    always_comb begin
        pick_idx     = '0;
        any_eligible = |eligible;
        for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
            if (eligible[i]) pick_idx = TAG_W'(i);
        end
        pick_onehot = '0;
        pick_onehot[pick_idx] = 1'b1;
    end
endmodule

// File: rtl/arb_split_tracker.sv
// Module: arb_split_tracker
// Keeps the data-phase owner tag and one split mask bit per master.
// A split response masks the data-phase owner. A release bit clears the
// mask and wins over a same-cycle split response.
// Assumes that release bits at or above NUM_MASTERS belong to no master.
module arb_split_tracker
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int TAG_W       = 4,
    parameter int SPLIT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ready,
    input  logic [1:0]             resp,
    input  logic [TAG_W-1:0]       owner,
    input  logic [SPLIT_W-1:0]     split_release,
    output logic [NUM_MASTERS-1:0] mask_q
);
    logic [TAG_W-1:0] dphase_tag_q;
    logic             split_seen;

    assign split_seen = (resp == RESP_SPLIT);

    // Copy the address-phase owner into the data-phase tag whenever a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)     dphase_tag_q <= '0;
        else if (ready) dphase_tag_q <= owner;
    end

    for (genvar n = 0; n < NUM_MASTERS; n++) begin : g_mask
        // Set on a split aimed at master n; a release of master n always wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        mask_q[n] <= 1'b0;
            else if (split_release[n])                         mask_q[n] <= 1'b0;
            else if (split_seen && dphase_tag_q == TAG_W'(n))  mask_q[n] <= 1'b1;
        end

        // R9
        release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            split_release[n] |=> !mask_q[n]);

        // R8
        split_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (split_seen && dphase_tag_q == TAG_W'(n) && !split_release[n]) |=> mask_q[n]);
    end

    if (SPLIT_W > NUM_MASTERS) begin : g_spare
        logic spare_any;
        assign spare_any = |split_release[SPLIT_W-1:NUM_MASTERS];
        // R11
        spare_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (spare_any && !(|split_release[NUM_MASTERS-1:0]) && !split_seen)
            |=> (mask_q == $past(mask_q)));
    end
endmodule

// File: rtl/arb_split_arbiter.sv
// Module: arb_split_arbiter (top)
// Fixed-priority arbiter with lock hold and split masking. The grant moves
// only at ready-high edges and stays put while the granted, unmasked master
// holds its lock line. The owner tag and locked flag follow the grant one
// ready-high edge later, in step with the address phase.
// Assumes NUM_MASTERS <= 2**TAG_W and NUM_MASTERS <= SPLIT_W.
module arb_split_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int TAG_W       = 4,
    parameter int SPLIT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] lock,
    input  logic                   ready,
    input  logic [1:0]             resp,
    input  logic [SPLIT_W-1:0]     split_release,
    output logic [NUM_MASTERS-1:0] grant,
    output logic [TAG_W-1:0]       owner,
    output logic                   owner_locked
);
    localparam int SEL_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    logic [NUM_MASTERS-1:0] grant_q;
    logic [TAG_W-1:0]       owner_q;
    logic                   olock_q;
    logic [NUM_MASTERS-1:0] mask_q;
    logic [NUM_MASTERS-1:0] eligible;
    logic [NUM_MASTERS-1:0] pick_onehot;
    logic [TAG_W-1:0]       pick_idx;
    logic                   any_eligible;
    logic [SEL_W-1:0]       cur_sel;
    logic                   hold;

    // Encode the current one-hot grant into an index.
    always_comb begin
        cur_sel = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (grant_q[i]) cur_sel = SEL_W'(i);
        end
    end

    assign eligible = req & ~mask_q;
    assign hold     = lock[cur_sel] && !mask_q[cur_sel];

    arb_fixed_pick #(
        .NUM_MASTERS (NUM_MASTERS),
        .TAG_W       (TAG_W)
    ) u_pick (
        .eligible     (eligible),
        .pick_onehot  (pick_onehot),
        .pick_idx     (pick_idx),
        .any_eligible (any_eligible)
    );

    arb_split_tracker #(
        .NUM_MASTERS (NUM_MASTERS),
        .TAG_W       (TAG_W),
        .SPLIT_W     (SPLIT_W)
    ) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .ready         (ready),
        .resp          (resp),
        .owner         (owner_q),
        .split_release (split_release),
        .mask_q        (mask_q)
    );

    // Advance the grant, owner tag and locked flag at ready-high edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= NUM_MASTERS'(1);
            owner_q <= '0;
            olock_q <= 1'b0;
        end else if (ready) begin
            owner_q <= TAG_W'(cur_sel);
            olock_q <= lock[cur_sel];
            if (!hold) grant_q <= pick_onehot;
        end
    end

    assign grant        = grant_q;
    assign owner        = owner_q;
    assign owner_locked = olock_q;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grant_q));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(grant_q) && $stable(owner_q) && $stable(olock_q)));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && hold) |=> $stable(grant_q));

    // R10
    default_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !hold && !any_eligible) |=> grant_q[0]);

    // R5
    owner_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (owner_q[SEL_W-1:0] == $past(cur_sel)));
endmodule

// File: tb/arb_split_arbiter_bench.sv
module arb_split_arbiter_bench;
    localparam int N  = 4;
    localparam int TW = 4;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req, lock;
    logic          ready;
    logic [1:0]    resp;
    logic [SW-1:0] rel;
    logic [N-1:0]  grant;
    logic [TW-1:0] owner;
    logic          owner_locked;

    int compared   = 0;
    int mismatched = 0;
    bit model_on   = 0;

    // Reference model state
    int     m_g, m_own, m_dp;
    bit     m_lk;
    bit     m_mask[N];

    always #5 clk = ~clk;

    arb_split_arbiter #(.NUM_MASTERS(N), .TAG_W(TW), .SPLIT_W(SW)) u_arb_split_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .ready(ready),
        .resp(resp), .split_release(rel), .grant(grant), .owner(owner),
        .owner_locked(owner_locked)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, stepped at every rising edge.
    always @(posedge clk) begin
        int pick;
        bit hold;
        bit nm[N];
        if (!rst_n) begin
            m_g = 0; m_own = 0; m_dp = 0; m_lk = 0;
            foreach (m_mask[i]) m_mask[i] = 0;
        end else begin
            pick = 0;
            for (int i = N - 1; i >= 0; i--) if (req[i] && !m_mask[i]) pick = i;
            hold = lock[m_g] && !m_mask[m_g];
            for (int i = 0; i < N; i++) begin
                if (rel[i]) nm[i] = 0;
                else if (resp == 2'b11 && m_dp == i) nm[i] = 1;
                else nm[i] = m_mask[i];
            end
            if (ready) begin
                m_dp = m_own;
                m_own = m_g;
                m_lk = lock[m_g];
                if (!hold) m_g = pick;
            end
            foreach (m_mask[i]) m_mask[i] = nm[i];
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            check("R3 grant", int'(grant), 1 << m_g);
            check("R5 owner", int'(owner), m_own);
            check("R6 owner_locked", int'(owner_locked), int'(m_lk));
            check("R2 onehot", $countones(grant), 1);
        end
    end

    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] lk, input logic rdy,
                        input logic [1:0] rs, input logic [SW-1:0] rl);
        req = rq; lock = lk; ready = rdy; resp = rs; rel = rl;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 0; req = '0; lock = '0; ready = 1; resp = 2'b00; rel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 grant", int'(grant), 1);
        check("R1 owner", int'(owner), 0);
        check("R1 owner_locked", int'(owner_locked), 0);
        rst_n = 1;
        model_on = 1;

        // R3 priority: master 1 is the lowest requester
        step(4'b1110, 4'b0000, 1'b1, 2'b00, '0);
        check("R3 lowest requester", int'(grant), 4'b0010);
        // Make master 1 the data-phase owner
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        // R9 collision: split and release of master 1 in the same cycle
        step(4'b0010, 4'b0000, 1'b0, 2'b11, 16'h0002);
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        check("R9 release beats split", int'(grant), 4'b0010);
        // R8 split alone masks master 1; R10 default master 0
        step(4'b0010, 4'b0000, 1'b0, 2'b11, '0);
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        check("R8 R10 masked to default", int'(grant), 4'b0001);
        // R11 release bit above the master count does nothing
        step(4'b0010, 4'b0000, 1'b1, 2'b00, 16'h0020);
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        check("R11 spare release ignored", int'(grant), 4'b0001);
        // R9 release restores master 1
        step(4'b0010, 4'b0000, 1'b1, 2'b00, 16'h0002);
        step(4'b0010, 4'b0000, 1'b1, 2'b00, '0);
        check("R9 release restores", int'(grant), 4'b0010);
        // R7 lock hold against higher priority master 0
        step(4'b0011, 4'b0010, 1'b1, 2'b00, '0);
        step(4'b0011, 4'b0010, 1'b1, 2'b00, '0);
        check("R7 lock hold", int'(grant), 4'b0010);
        check("R6 locked flag", int'(owner_locked), 1);
        step(4'b0011, 4'b0000, 1'b1, 2'b00, '0);
        check("R7 lock released", int'(grant), 4'b0001);
        // R4 ready low freezes everything
        step(4'b1100, 4'b0000, 1'b0, 2'b00, '0);
        check("R4 grant frozen", int'(grant), 4'b0001);
        check("R4 owner frozen", int'(owner), 1);

        // Mixed traffic
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0]  rq, lk;
            logic [SW-1:0] rl;
            logic [1:0]    rs;
            rq = N'($urandom);
            lk = (($urandom % 4) == 0) ? N'($urandom) : '0;
            rs = (($urandom % 6) == 0) ? 2'b11 : 2'($urandom % 3);
            rl = (($urandom % 5) == 0) ? SW'(1 << ($urandom % SW)) : '0;
            step(rq, lk, (($urandom % 4) != 0), rs, rl);
        end

        model_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule